// File: doc/BRIEF.md
# Little-Endian Byte-Lane Aligner for a 64-Bit Bus

This block connects an internal requester to a 64-bit external data bus whose byte lanes are numbered little-endian: lane k carries bits 8k+7..8k and holds the byte whose address has k in its low three bits. A requester issues one request at a time: a byte, a 16-bit word, a 32-bit longword or a 32-byte line, as a read or a write. For the three single sizes the block shifts write data up to the lanes selected by the low address bits, raises one byte enable per lane it uses, and moves read data back down into the low bits of a 32-bit result.

A line request becomes four 8-byte beats on the bus, each with a valid/ready handshake. The first beat is the 8-byte group the request address points into. Each later beat moves 8 bytes higher in the line, and after the top of the 32-byte line the next beat goes back to the line's first group. Write data and returned read data for a line are held as a 256-bit vector indexed by position in the line, so the wrap order never shows to the requester. A single-size request whose address is not a multiple of its size is rejected with an error response, and no beat appears on the bus.

Top module: `lane_aligner`

## Requirements
- R1: A byte request at group offset k (address bits 2..0) produces exactly one beat with byte enable bit k alone set, the write byte on bits 8k+7..8k and every other lane zero.
- R2: A word request at offset k in {0,2,4,6} enables lanes k and k+1, with the low data byte on lane k and the high byte on lane k+1.
- R3: A longword request at offset 0 enables lanes 0-3 (bits 31..0) and at offset 4 enables lanes 4-7 (bits 63..32), with the least significant byte on the lowest enabled lane.
- R4: A single-size request gives one beat with bus_last high and bus_addr equal to the request address with bits 2..0 cleared. For a read, bus_wdata is zero.
- R5: For a single-size read, rsp_rdata holds the enabled lanes moved down to bit 0, lowest lane lowest, with zero in all bits above the access size.
- R6: A single-size request whose offset is not a multiple of its size (1, 2 or 4 bytes) returns rsp_err high and produces no beat. Line requests never raise the error.
- R7: req_size = 3 selects a line request, which produces exactly four beats with all eight byte enables set and bus_last high on the fourth beat only.
- R8: The line beat addresses start at the group selected by address bits 4..3, rise by 8 per beat and wrap to the start of the same 32-byte line. Address bits 2..0 of a line request are ignored.
- R9: Line data is ordered by line position: the beat at line offset 8b carries bytes 8b..8b+7 of req_line_wdata (byte j at bits 8j+7..8j) with the lowest byte on bits 7..0. Read beats are stored into rsp_line_rdata using the same byte positions.
- R10: While bus_valid is high and bus_ready is low, bus_addr, bus_be, bus_wdata and bus_valid hold their values into the next cycle.
- R11: rsp_valid is a one-cycle pulse in the cycle after the last beat's handshake, or in the cycle after an erroneous request is accepted. req_ready is high only when no request is in progress and no response is being shown.
- R12: After reset, bus_valid and rsp_valid are low and req_ready is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Block can accept a request |
| req_write | input | 1 | 1 = write, 0 = read |
| req_size | input | 2 | 0 byte, 1 word, 2 longword, 3 line |
| req_addr | input | ADDR_W | Byte address of the request |
| req_wdata | input | 32 | Single-size write data, right-justified |
| req_line_wdata | input | 256 | Line write data, byte j at bits 8j+7..8j |
| bus_valid | output | 1 | Beat present on the bus |
| bus_ready | input | 1 | Bus takes the beat this cycle |
| bus_addr | output | ADDR_W | Beat address, bits 2..0 zero |
| bus_be | output | 8 | Per-lane byte enables |
| bus_wdata | output | 64 | Lane-aligned write data |
| bus_last | output | 1 | Final beat of the request |
| bus_rdata | input | 64 | Read data, sampled on the handshake |
| rsp_valid | output | 1 | Response pulse |
| rsp_err | output | 1 | Misaligned request |
| rsp_rdata | output | 32 | Right-justified, zero-extended read data |
| rsp_line_rdata | output | 256 | Line read data in line byte order |

## Verification
The assertions check on every cycle that a byte beat enables exactly one lane and a word beat exactly two, that line beats enable all lanes, that a stalled beat is held, that successive line beats step one group up within the same line, that an error response is never paired with a bus beat, and that the response lasts one cycle. The data itself can only be checked by the bench's scenarios: which bytes land on which lanes, the right-justified read result, the wrapped beat order for every start group, and the line data reassembled in line order. The bench covers these by sweeping every size, offset and direction against a bus model that stalls at irregular points.

// File: rtl/lane_align_pkg.sv
// Shared types and helpers for the byte-lane aligner.
// Assumes the request size code is 2 bits wide and that code 3 is a line.
package lane_align_pkg;

    typedef enum logic [1:0] {
        SZ_BYTE = 2'd0,
        SZ_WORD = 2'd1,
        SZ_LONG = 2'd2,
        SZ_LINE = 2'd3
    } xfer_size_e;

    // Number of bytes moved by a single-size request; a line returns 0.
    function automatic int size_nbytes(xfer_size_e sz);
        case (sz)
            SZ_BYTE: return 1;
            SZ_WORD: return 2;
            SZ_LONG: return 4;
            default: return 0;
        endcase
    endfunction

endpackage

// File: rtl/lane_steer.sv
// Write-side lane steering for single-size requests.
// Shifts right-justified write data up to the lanes chosen by the group
// offset and builds the matching byte enables. Lanes not used are zero.
// Assumes the offset has already been checked for alignment and that
// SINGLE_BYTES <= BUS_BYTES.
module lane_steer
    import lane_align_pkg::*;
#(
    parameter int BUS_BYTES    = 8,
    parameter int SINGLE_BYTES = 4,
    localparam int OFF_W    = $clog2(BUS_BYTES),
    localparam int BUS_W    = 8 * BUS_BYTES,
    localparam int SINGLE_W = 8 * SINGLE_BYTES
) (
    input  xfer_size_e            size,
    input  logic [OFF_W-1:0]      offset,
    input  logic [SINGLE_W-1:0]   wdata,
    output logic [BUS_BYTES-1:0]  be,
    output logic [BUS_W-1:0]      wdata_bus
);

    logic [SINGLE_BYTES-1:0] keep_bytes;
    logic [SINGLE_W-1:0]     keep_mask;

    // One keep flag per source byte: set for the bytes the size covers.
    for (genvar i = 0; i < SINGLE_BYTES; i++) begin : g_keep
        assign keep_bytes[i]       = (i < size_nbytes(size));
        assign keep_mask[8*i +: 8] = {8{keep_bytes[i]}};
    end

    // Move enables and masked data up by the group offset.
    assign be        = BUS_BYTES'(keep_bytes) << offset;
    assign wdata_bus = BUS_W'(wdata & keep_mask) << {offset, 3'b000};

endmodule

// File: rtl/lane_extract.sv
// Read-side realignment for single-size requests.
// Moves the lanes chosen by the group offset down to bit 0 and clears
// every byte above the access size. Assumes an aligned offset.
module lane_extract
    import lane_align_pkg::*;
#(
    parameter int BUS_BYTES    = 8,
    parameter int SINGLE_BYTES = 4,
    localparam int OFF_W    = $clog2(BUS_BYTES),
    localparam int BUS_W    = 8 * BUS_BYTES,
    localparam int SINGLE_W = 8 * SINGLE_BYTES
) (
    input  xfer_size_e           size,
    input  logic [OFF_W-1:0]     offset,
    input  logic [BUS_W-1:0]     rdata_bus,
    output logic [SINGLE_W-1:0]  rdata
);

    logic [SINGLE_W-1:0] keep_mask;
    logic [BUS_W-1:0]    shifted;

    // Per result byte: keep it only if it lies inside the access size.
    for (genvar i = 0; i < SINGLE_BYTES; i++) begin : g_keep
        assign keep_mask[8*i +: 8] = {8{i < size_nbytes(size)}};
    end

    // Shift down to bit 0, then zero-extend above the access size.
    assign shifted = rdata_bus >> {offset, 3'b000};
    assign rdata   = shifted[SINGLE_W-1:0] & keep_mask;

endmodule

// File: rtl/beat_seq.sv
// Beat address sequencer.
// Loads the 8-byte group address of a request and walks the groups of the
// enclosing line, wrapping inside it. A single-size request is one beat.
// Assumes LINE_BEATS is a power of two and that load and advance never
// occur in the same cycle.
module beat_seq #(
    parameter int ADDR_W     = 32,
    parameter int BUS_BYTES  = 8,
    parameter int LINE_BEATS = 4,
    localparam int OFF_W  = $clog2(BUS_BYTES),
    localparam int BEAT_W = $clog2(LINE_BEATS),
    localparam int GRP_W  = ADDR_W - OFF_W,
    localparam int HI_W   = GRP_W - BEAT_W
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               load,
    input  logic [GRP_W-1:0]   load_group,
    input  logic               load_line,
    input  logic               advance,
    output logic [ADDR_W-1:0]  beat_addr,
    output logic [BEAT_W-1:0]  beat_idx,
    output logic               beat_last
);

    logic [HI_W-1:0]   hi_q;
    logic [BEAT_W-1:0] first_q;
    logic [BEAT_W-1:0] cnt_q;
    logic              line_q;

    // Capture the request group on load; count beats on each handshake.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            hi_q    <= '0;
            first_q <= '0;
            cnt_q   <= '0;
            line_q  <= 1'b0;
        end else if (load) begin
            hi_q    <= load_group[GRP_W-1 -: HI_W];
            first_q <= load_group[BEAT_W-1:0];
            cnt_q   <= '0;
            line_q  <= load_line;
        end else if (advance && !beat_last) begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

    // Position in the line wraps naturally in BEAT_W bits.
    assign beat_idx  = first_q + cnt_q;
    assign beat_addr = {hi_q, beat_idx, {OFF_W{1'b0}}};
    assign beat_last = !line_q || (cnt_q == BEAT_W'(LINE_BEATS - 1));

    // Each accepted non-final beat is followed by the next group of the same line.
    assert_beat_wrap_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (advance && !beat_last) |=>
            (beat_idx == BEAT_W'($past(beat_idx) + 1'b1)) && $stable(hi_q));

endmodule

// File: rtl/lane_aligner.sv
// Little-endian byte-lane aligner, top level.
// Accepts one request at a time, rejects misaligned single-size requests,
// drives one beat (single) or four wrapped beats (line) on the 64-bit bus
// and returns a one-cycle response. Assumes the bus keeps bus_rdata valid
// in the cycle it raises bus_ready for a read beat.
module lane_aligner
    import lane_align_pkg::*;
#(
    parameter int ADDR_W       = 32,
    parameter int BUS_BYTES    = 8,
    parameter int LINE_BEATS   = 4,
    parameter int SINGLE_BYTES = 4,
    localparam int OFF_W    = $clog2(BUS_BYTES),
    localparam int BEAT_W   = $clog2(LINE_BEATS),
    localparam int BUS_W    = 8 * BUS_BYTES,
    localparam int LINE_W   = BUS_W * LINE_BEATS,
    localparam int SINGLE_W = 8 * SINGLE_BYTES
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  req_valid,
    output logic                  req_ready,
    input  logic                  req_write,
    input  logic [1:0]            req_size,
    input  logic [ADDR_W-1:0]     req_addr,
    input  logic [SINGLE_W-1:0]   req_wdata,
    input  logic [LINE_W-1:0]     req_line_wdata,
    output logic                  bus_valid,
    input  logic                  bus_ready,
    output logic [ADDR_W-1:0]     bus_addr,
    output logic [BUS_BYTES-1:0]  bus_be,
    output logic [BUS_W-1:0]      bus_wdata,
    output logic                  bus_last,
    input  logic [BUS_W-1:0]      bus_rdata,
    output logic                  rsp_valid,
    output logic                  rsp_err,
    output logic [SINGLE_W-1:0]   rsp_rdata,
    output logic [LINE_W-1:0]     rsp_line_rdata
);

    typedef enum logic {ST_IDLE, ST_BUSY} state_e;

    state_e               state_q;
    logic                 wr_q;
    xfer_size_e           size_q;
    logic [OFF_W-1:0]     off_q;
    logic [SINGLE_W-1:0]  wdata_q;
    logic [LINE_W-1:0]    line_wdata_q;
    logic [LINE_W-1:0]    line_buf_q;

    xfer_size_e           req_sz;
    logic [OFF_W-1:0]     req_off;
    logic                 misaligned;
    logic                 accept;
    logic                 start_ok;
    logic                 handshake;
    logic                 is_line;
    logic [BEAT_W-1:0]    beat_idx;
    logic                 beat_last;
    logic [BUS_BYTES-1:0] steer_be;
    logic [BUS_W-1:0]     steer_wdata;
    logic [SINGLE_W-1:0]  extract_rdata;

    // Request decode: size, group offset and alignment check.
    always_comb begin
        req_sz     = xfer_size_e'(req_size);
        req_off    = req_addr[OFF_W-1:0];
        misaligned = (req_sz != SZ_LINE) &&
                     ((req_off & OFF_W'(size_nbytes(req_sz) - 1)) != '0);
    end

    assign req_ready = (state_q == ST_IDLE) && !rsp_valid;
    assign accept    = req_valid && req_ready;
    assign start_ok  = accept && !misaligned;
    assign bus_valid = (state_q == ST_BUSY);
    assign handshake = bus_valid && bus_ready;
    assign is_line   = (size_q == SZ_LINE);

    // Beat address generation and line wrap.
    beat_seq #(
        .ADDR_W     (ADDR_W),
        .BUS_BYTES  (BUS_BYTES),
        .LINE_BEATS (LINE_BEATS)
    ) u_seq (
        .clk        (clk),
        .rst_n      (rst_n),
        .load       (start_ok),
        .load_group (req_addr[ADDR_W-1:OFF_W]),
        .load_line  (req_sz == SZ_LINE),
        .advance    (handshake),
        .beat_addr  (bus_addr),
        .beat_idx   (beat_idx),
        .beat_last  (beat_last)
    );

    // Write lane steering for single-size beats.
    lane_steer #(
        .BUS_BYTES    (BUS_BYTES),
        .SINGLE_BYTES (SINGLE_BYTES)
    ) u_steer (
        .size      (size_q),
        .offset    (off_q),
        .wdata     (wdata_q),
        .be        (steer_be),
        .wdata_bus (steer_wdata)
    );

    // Read realignment for single-size beats.
    lane_extract #(
        .BUS_BYTES    (BUS_BYTES),
        .SINGLE_BYTES (SINGLE_BYTES)
    ) u_extract (
        .size      (size_q),
        .offset    (off_q),
        .rdata_bus (bus_rdata),
        .rdata     (extract_rdata)
    );

    // Bus-side beat contents.
    always_comb begin
        bus_last = beat_last;
        if (is_line) begin
            bus_be    = '1;
            bus_wdata = wr_q ? line_wdata_q[int'(beat_idx)*BUS_W +: BUS_W] : '0;
        end else begin
            bus_be    = steer_be;
            bus_wdata = wr_q ? steer_wdata : '0;
        end
    end

    // Control state and captured request fields.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q      <= ST_IDLE;
            wr_q         <= 1'b0;
            size_q       <= SZ_BYTE;
            off_q        <= '0;
            wdata_q      <= '0;
            line_wdata_q <= '0;
        end else if (start_ok) begin
            state_q      <= ST_BUSY;
            wr_q         <= req_write;
            size_q       <= req_sz;
            off_q        <= req_off;
            wdata_q      <= req_wdata;
            line_wdata_q <= req_line_wdata;
        end else if (handshake && beat_last) begin
            state_q <= ST_IDLE;
        end
    end

    // Response pulse and error flag.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rsp_valid <= 1'b0;
            rsp_err   <= 1'b0;
        end else begin
            rsp_valid <= (accept && misaligned) || (handshake && beat_last);
            rsp_err   <= accept && misaligned;
        end
    end

    // Read data capture: single result and line buffer by line position.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rsp_rdata  <= '0;
            line_buf_q <= '0;
        end else if (handshake && !wr_q) begin
            if (is_line) begin
                line_buf_q[int'(beat_idx)*BUS_W +: BUS_W] <= bus_rdata;
            end else begin
                rsp_rdata <= extract_rdata;
            end
        end
    end

    assign rsp_line_rdata = line_buf_q;

    // A byte beat drives exactly one lane.
    assert_byte_one_lane_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_valid && size_q == SZ_BYTE) |-> ($countones(bus_be) == 1));

    // A word beat drives exactly two lanes.
    assert_word_two_lanes_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_valid && size_q == SZ_WORD) |-> ($countones(bus_be) == 2));

    // Line beats enable every lane.
    assert_line_all_lanes_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_valid && is_line) |-> (bus_be == '1));

    // A stalled beat is held unchanged.
    assert_stall_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_valid && !bus_ready) |=>
            (bus_valid && $stable(bus_addr) && $stable(bus_be) && $stable(bus_wdata)));

    // An error response never comes with a bus beat.
    assert_err_no_beat_R6: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_err |-> (!bus_valid && rsp_valid));

    // The response lasts exactly one cycle.
    assert_rsp_pulse_R11: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |=> !rsp_valid);

endmodule

// File: tb/lane_aligner_bench.sv
// Sweeps every size, offset and direction plus every line start group,
// with a stalling bus model whose read bytes are a function of address.
module lane_aligner_bench;

    localparam int ADDR_W = 16;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          req_valid = 1'b0;
    logic          req_ready;
    logic          req_write = 1'b0;
    logic [1:0]    req_size = 2'd0;
    logic [15:0]   req_addr = '0;
    logic [31:0]   req_wdata = '0;
    logic [255:0]  req_line_wdata = '0;
    logic          bus_valid;
    logic          bus_ready = 1'b0;
    logic [15:0]   bus_addr;
    logic [7:0]    bus_be;
    logic [63:0]   bus_wdata;
    logic          bus_last;
    logic [63:0]   bus_rdata = '0;
    logic          rsp_valid;
    logic          rsp_err;
    logic [31:0]   rsp_rdata;
    logic [255:0]  rsp_line_rdata;

    int checks = 0;
    int errors = 0;
    int cyc = 0;
    bit done = 1'b0;

    always #5ns clk = ~clk;

    lane_aligner #(.ADDR_W(ADDR_W)) u_lane_aligner (
        .clk(clk), .rst_n(rst_n),
        .req_valid(req_valid), .req_ready(req_ready), .req_write(req_write),
        .req_size(req_size), .req_addr(req_addr), .req_wdata(req_wdata),
        .req_line_wdata(req_line_wdata),
        .bus_valid(bus_valid), .bus_ready(bus_ready), .bus_addr(bus_addr),
        .bus_be(bus_be), .bus_wdata(bus_wdata), .bus_last(bus_last),
        .bus_rdata(bus_rdata),
        .rsp_valid(rsp_valid), .rsp_err(rsp_err), .rsp_rdata(rsp_rdata),
        .rsp_line_rdata(rsp_line_rdata)
    );

    // Memory model: the byte stored at an address.
    function automatic logic [7:0] mem_byte(input logic [15:0] a);
        return 8'(a[7:0] * 8'd29 + a[15:8] + 8'h11);
    endfunction

    task automatic check(input string req, input logic [255:0] act, input logic [255:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // Issue one request, play the bus and check every beat and the response.
    task automatic run_req(input bit w, input logic [1:0] sz, input logic [15:0] a,
                           input logic [31:0] wd, input logic [255:0] lwd);
        int n;
        int off;
        bit line;
        bit mis;
        int exp_beats;
        int beats;
        bit got_rsp;
        bit stalled;
        bit busy_seen;
        logic [15:0] held_addr;
        logic [7:0]  held_be;
        logic [63:0] held_wd;
        string tag;
        n    = (sz == 2'd0) ? 1 : (sz == 2'd1) ? 2 : (sz == 2'd2) ? 4 : 8;
        off  = int'(a[2:0]);
        line = (sz == 2'd3);
        mis  = !line && ((off % n) != 0);
        exp_beats = mis ? 0 : (line ? 4 : 1);
        tag  = (sz == 2'd0) ? "R1" : (sz == 2'd1) ? "R2" : "R3";

        check("R11 req_ready idle", 256'(req_ready), 256'(1));
        req_valid = 1'b1; req_write = w; req_size = sz; req_addr = a;
        req_wdata = wd; req_line_wdata = lwd;
        @(negedge clk);
        req_valid = 1'b0;
        beats = 0; got_rsp = 1'b0; stalled = 1'b0; busy_seen = 1'b0;
        held_addr = '0; held_be = '0; held_wd = '0;
        for (int it = 0; it < 60 && !got_rsp; it++) begin
            cyc++;
            if (rsp_valid) begin
                got_rsp = 1'b1;
                bus_ready = 1'b0;
                check("R6 rsp_err", 256'(rsp_err), 256'(mis));
                check(mis ? "R6 beat count" : (line ? "R7 beat count" : "R4 beat count"),
                      256'(beats), 256'(exp_beats));
                check("R11 req_ready low during rsp", 256'(req_ready), 256'(0));
                if (!w && !mis && !line) begin
                    logic [31:0] er;
                    er = '0;
                    for (int i = 0; i < n; i++)
                        er[8*i +: 8] = mem_byte({a[15:3], 3'b000} + 16'(off + i));
                    check("R5 rsp_rdata", 256'(rsp_rdata), 256'(er));
                end
                if (!w && line) begin
                    logic [255:0] el;
                    for (int j = 0; j < 32; j++)
                        el[8*j +: 8] = mem_byte({a[15:5], 5'b0} + 16'(j));
                    check("R9 line read data", rsp_line_rdata, el);
                end
            end else if (bus_valid) begin
                if (!busy_seen) begin
                    busy_seen = 1'b1;
                    check("R11 req_ready low while busy", 256'(req_ready), 256'(0));
                end
                if (stalled)
                    check("R10 held beat", {bus_addr, bus_be, bus_wdata},
                          {held_addr, held_be, held_wd});
                if ((cyc % 3) == 1) begin
                    bus_ready = 1'b0;
                    stalled = 1'b1;
                    held_addr = bus_addr; held_be = bus_be; held_wd = bus_wdata;
                end else begin
                    logic [15:0] ea;
                    logic [7:0]  eb;
                    logic [63:0] ew;
                    stalled = 1'b0;
                    bus_ready = 1'b1;
                    if (line) begin
                        int g;
                        g  = (int'(a[4:3]) + beats) % 4;
                        ea = {a[15:5], 5'b0} + 16'(g * 8);
                        eb = 8'hFF;
                        ew = w ? lwd[g*64 +: 64] : 64'h0;
                        check("R8 line beat addr", 256'(bus_addr), 256'(ea));
                        check("R7 line be", 256'(bus_be), 256'(eb));
                        check("R9 line write lanes", 256'(bus_wdata), 256'(ew));
                        check("R7 last flag", 256'(bus_last), 256'(beats == 3));
                    end else begin
                        ea = {a[15:3], 3'b000};
                        eb = 8'(((1 << n) - 1) << off);
                        ew = '0;
                        if (w)
                            for (int i = 0; i < n; i++) ew[8*(off+i) +: 8] = wd[8*i +: 8];
                        check("R4 single addr", 256'(bus_addr), 256'(ea));
                        check("R4 single last", 256'(bus_last), 256'(1));
                        check({tag, " be"}, 256'(bus_be), 256'(eb));
                        check({tag, " wdata lanes"}, 256'(bus_wdata), 256'(ew));
                    end
                    for (int i = 0; i < 8; i++)
                        bus_rdata[8*i +: 8] = mem_byte(bus_addr + 16'(i));
                    beats++;
                end
            end
            @(negedge clk);
        end
        bus_ready = 1'b0;
        if (!got_rsp) check("R11 response arrived", 256'(0), 256'(1));
        @(negedge clk);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        check("R12 reset bus_valid", 256'(bus_valid), 256'(0));
        check("R12 reset rsp_valid", 256'(rsp_valid), 256'(0));
        check("R12 reset req_ready", 256'(req_ready), 256'(1));
        rst_n = 1'b1;
        @(negedge clk);
        // Single sizes: every offset, both directions.
        for (int w = 0; w < 2; w++)
            for (int sz = 0; sz < 3; sz++)
                for (int off = 0; off < 8; off++)
                    run_req(w[0], 2'(sz), 16'h3A40 + 16'(sz * 64) + 16'(off),
                            32'hA1B2C3D4 ^ 32'(off * 32'h01010101), 256'h0);
        // Line requests: every start group, aligned and with ignored low bits.
        for (int w = 0; w < 2; w++)
            for (int sb = 0; sb < 4; sb++)
                for (int lo = 0; lo < 2; lo++) begin
                    logic [255:0] lw;
                    for (int j = 0; j < 32; j++) lw[8*j +: 8] = 8'(j * 13 + sb + 7 * w);
                    run_req(w[0], 2'd3, 16'h7F20 + 16'(sb * 8) + 16'(lo * 5), 32'h0, lw);
                end
        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    // Watchdog: a hung run is a failure and still prints the summary.
    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog R11 actual=hung expected=done");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

endmodule